// File: doc/BRIEF.md
# Grid Phase Synchronizer Without a Tracking Loop

This block turns sampled three-phase supply voltages into a unit sine/cosine pair locked to the supply fundamental. It needs no phase-tracking loop. Each sample first goes through a two-row Clarke projection onto a stationary alpha/beta frame. A pair of cross-coupled leaky integrators, tuned to 50 Hz, then strips harmonics and most of the negative-sequence content from that frame. The filtered vector is finally divided by its own length, which gives a phase reference of constant amplitude.

The filter runs once per sample strobe and is discretized with forward Euler for a 10 kHz sample rate. Magnitude and division run bit-serially. The result therefore appears a fixed number of clock cycles after each strobe. When the filtered vector is too short for a meaningful division, the previous phase outputs are kept. A current-control loop downstream can use the pair directly as its rotation reference.

Top module: `gsync_top`

## Requirements
- R1: Reset (active-low, asynchronous) clears both filter states and both phase outputs to zero and holds `sync_valid_o` low. After reset, a zero-voltage sample therefore leaves both outputs at zero.
- R2: On each strobe the frame components are alpha = floor((2·va − vb − vc)·10923 / 2^15) and beta = floor((vb − vc)·18919 / 2^15), where va, vb and vc are signed 16-bit integers.
- R3: Each strobe updates the 18-bit signed states once, using the old values: xa' = sat(xa + floor(131·(alpha − xa)/2^16) − floor(2059·xb/2^16)) and xb' = sat(xb + floor(131·(beta − xb)/2^16) + floor(2059·xa/2^16)). Here sat clamps to [−131072, 131071]. Without a strobe the states do not change.
- R4: The magnitude used for normalization is m = floor(sqrt(xa'² + xb'²)), taken from the updated states.
- R5: When m ≥ 64, `sin_o` = xa'·2^14 / m and `cos_o` = xb'·2^14 / m. Both quotients are truncated toward zero and given as signed 16-bit values with 14 fraction bits. The outputs change only in the cycle in which `sync_valid_o` rises.
- R6: When m < 64, `sin_o` and `cos_o` keep their previous values, and `sync_valid_o` still pulses.
- R7: `sync_valid_o` is high for exactly one cycle. That cycle follows the 37th rising edge after the edge that sampled `smp_valid_i` high.
- R8: Take va = A·sin θ + harmonics, vb = B·sin(θ − 120°) + harmonics and vc = C·sin(θ + 120°) + harmonics, with unequal A, B, C, 3rd/5th/7th/9th harmonics and θ advancing 2π·50/10000 per sample. After settling, `sin_o`/2^14 lies within 0.05 of sin θ and `cos_o`/2^14 lies within 0.05 of −cos θ, with θ taken at the following sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | One-cycle strobe marking a new voltage sample |
| va_i | input | 16 | Phase A voltage sample, signed |
| vb_i | input | 16 | Phase B voltage sample, signed |
| vc_i | input | 16 | Phase C voltage sample, signed |
| sync_valid_o | output | 1 | One-cycle pulse when a new phase pair is ready |
| sin_o | output | 16 | Sine reference, signed, 14 fraction bits |
| cos_o | output | 16 | Cosine reference, signed, 14 fraction bits |

## Verification
The assertions assume that no new strobe arrives while a normalization is still in progress. Strobes must therefore be at least 38 cycles apart, which a real 10 kHz sample clock satisfies by a wide margin. The bench holds to this by sending each sample only after the previous `sync_valid_o` pulse has ended. The assertions also assume that reset is applied only when no sample is in flight, and the bench issues its mid-run reset only after a completed result.

// File: rtl/gsync_pkg.sv
package gsync_pkg;
  parameter int VIN_W    = 16;
  parameter int AB_W     = VIN_W + 1;
  parameter int ST_W     = VIN_W + 2;
  parameter int CF_W     = 15;
  parameter int A_COEF   = 10923;
  parameter int B_COEF   = 18919;
  parameter int GF_W     = 16;
  parameter int KT_COEF  = 131;
  parameter int WT_COEF  = 2059;
  parameter int OUT_FRAC = 14;
  parameter int OUT_W    = OUT_FRAC + 2;
  parameter int ROOT_W   = ST_W;
  parameter int RAD_W    = 2 * ST_W;
  parameter int SQ_ITER  = RAD_W / 2;
  parameter int DIV_ITER = OUT_FRAC + 1;
  parameter int LATENCY  = SQ_ITER + DIV_ITER + 4;
  parameter int MAG_MIN  = 64;
  localparam int WIDE    = 48;

  typedef logic signed [VIN_W-1:0] vin_t;
  typedef logic signed [AB_W-1:0]  ab_t;
  typedef logic signed [ST_W-1:0]  st_t;

  localparam logic signed [WIDE-1:0] ST_HI = WIDE'((64'sd1 <<< (ST_W - 1)) - 64'sd1);
  localparam logic signed [WIDE-1:0] ST_LO = -ST_HI - WIDE'(1);

  // alpha row of the projection, floor rounding via arithmetic shift
  function automatic ab_t f_alpha(input vin_t va, input vin_t vb, input vin_t vc);
    logic signed [WIDE-1:0] p;
    p = (WIDE'(2) * WIDE'(va) - WIDE'(vb) - WIDE'(vc)) * WIDE'(A_COEF);
    return ab_t'(p >>> CF_W);
  endfunction

  // beta row of the projection
  function automatic ab_t f_beta(input vin_t vb, input vin_t vc);
    logic signed [WIDE-1:0] p;
    p = (WIDE'(vb) - WIDE'(vc)) * WIDE'(B_COEF);
    return ab_t'(p >>> CF_W);
  endfunction

  function automatic st_t f_sat(input logic signed [WIDE-1:0] v);
    if (v > ST_HI) return st_t'(ST_HI);
    if (v < ST_LO) return st_t'(ST_LO);
    return st_t'(v);
  endfunction

  // one forward-Euler step of a cross-coupled integrator axis
  function automatic st_t f_stf_next(input st_t own, input st_t oth, input ab_t inp,
                                     input logic plus, input int kt, input int wt);
    logic signed [WIDE-1:0] eo, g, c;
    eo = WIDE'(own);
    g  = ((WIDE'(inp) - eo) * WIDE'(kt)) >>> GF_W;
    c  = (WIDE'(oth) * WIDE'(wt)) >>> GF_W;
    return f_sat(plus ? (eo + g + c) : (eo + g - c));
  endfunction

  function automatic logic [ST_W-1:0] f_abs(input st_t v);
    st_t n;
    n = -v;
    return v[ST_W-1] ? n : v;
  endfunction
endpackage

// File: rtl/gsync_clarke.sv
module gsync_clarke
  import gsync_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid_i,
  input  logic signed [VIN_W-1:0] va_i,
  input  logic signed [VIN_W-1:0] vb_i,
  input  logic signed [VIN_W-1:0] vc_i,
  output logic signed [AB_W-1:0]  alpha_o,
  output logic signed [AB_W-1:0]  beta_o,
  output logic                   v_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alpha_o <= '0;
      beta_o  <= '0;
      v_o     <= 1'b0;
    end else begin
      v_o <= in_valid_i;
      if (in_valid_i) begin
        alpha_o <= f_alpha(va_i, vb_i, vc_i);
        beta_o  <= f_beta(vb_i, vc_i);
      end
    end
  end

  // frame registers move only on a strobe (R2)
  p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(alpha_o) && $stable(beta_o)));
endmodule

// File: rtl/gsync_stf.sv
module gsync_stf
  import gsync_pkg::*;
#(
  parameter int KT = KT_COEF,
  parameter int WT = WT_COEF
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_i,
  input  logic signed [AB_W-1:0] alpha_i,
  input  logic signed [AB_W-1:0] beta_i,
  output logic signed [ST_W-1:0] xa_o,
  output logic signed [ST_W-1:0] xb_o,
  output logic                  v_o
);
  ab_t in_w [2];
  st_t st_q [2];

  assign in_w[0] = alpha_i;
  assign in_w[1] = beta_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q[0] <= '0;
      st_q[1] <= '0;
      v_o     <= 1'b0;
    end else begin
      v_o <= upd_i;
      if (upd_i) begin
        for (int g = 0; g < 2; g++) begin
          st_q[g] <= f_stf_next(st_q[g], st_q[1-g], in_w[g], (g == 1), KT, WT);
        end
      end
    end
  end

  assign xa_o = st_q[0];
  assign xb_o = st_q[1];

  // integrator state is frozen between strobes (R3)
  p_state_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(xa_o) && $stable(xb_o)));
endmodule

// File: rtl/gsync_norm.sv
module gsync_norm
  import gsync_pkg::*;
#(
  parameter int MAG_LIMIT = MAG_MIN
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic signed [ST_W-1:0]  xa_i,
  input  logic signed [ST_W-1:0]  xb_i,
  output logic                   valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int STEP_W = $clog2(SQ_ITER + DIV_ITER + 2);
  localparam int SR_W   = ROOT_W + 4;
  localparam int DR_W   = ROOT_W + 2;
  localparam logic [STEP_W-1:0] SQ_END   = STEP_W'(SQ_ITER);
  localparam logic [STEP_W-1:0] FIN_STEP = STEP_W'(SQ_ITER + DIV_ITER + 1);
  localparam logic [ROOT_W-1:0] MAG_LO   = ROOT_W'(MAG_LIMIT);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [RAD_W-1:0]  rad_q, rad_keep_q;
  logic [ROOT_W-1:0] root_q;
  logic [SR_W-1:0]   srem_q;
  logic              small_q;

  // named internal events
  logic start_w, sq_step_w, sq_done_w, div_step_w, fin_w;
  assign start_w    = start_i && !busy_q;
  assign sq_step_w  = busy_q && (step_q < SQ_END);
  assign sq_done_w  = busy_q && (step_q == SQ_END);
  assign div_step_w = busy_q && (step_q > SQ_END) && (step_q < FIN_STEP);
  assign fin_w      = busy_q && (step_q == FIN_STEP);

  st_t x_w [2];
  logic [ST_W-1:0] abs_w [2];
  logic [ST_W-1:0] abs_q [2];
  logic signed [OUT_W-1:0] lane_val [2];
  assign x_w[0] = xa_i;
  assign x_w[1] = xb_i;
  assign abs_w[0] = f_abs(xa_i);
  assign abs_w[1] = f_abs(xb_i);

  logic [RAD_W-1:0] rad_w;
  assign rad_w = RAD_W'(abs_w[0]) * RAD_W'(abs_w[0]) + RAD_W'(abs_w[1]) * RAD_W'(abs_w[1]);

  // one bit of floor square root per step
  logic [SR_W-1:0] srem_sh, trial_w;
  logic            take_w;
  assign srem_sh = {srem_q[SR_W-3:0], rad_q[RAD_W-1:RAD_W-2]};
  assign trial_w = {2'b00, root_q, 2'b01};
  assign take_w  = srem_sh >= trial_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      step_q     <= '0;
      rad_q      <= '0;
      rad_keep_q <= '0;
      root_q     <= '0;
      srem_q     <= '0;
      small_q    <= 1'b0;
      abs_q[0]   <= '0;
      abs_q[1]   <= '0;
      valid_o    <= 1'b0;
      sin_o      <= '0;
      cos_o      <= '0;
    end else begin
      valid_o <= 1'b0;
      if (start_w) begin
        busy_q     <= 1'b1;
        step_q     <= '0;
        rad_q      <= rad_w;
        rad_keep_q <= rad_w;
        root_q     <= '0;
        srem_q     <= '0;
        abs_q[0]   <= abs_w[0];
        abs_q[1]   <= abs_w[1];
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (sq_step_w) begin
          rad_q  <= {rad_q[RAD_W-3:0], 2'b00};
          srem_q <= take_w ? (srem_sh - trial_w) : srem_sh;
          root_q <= {root_q[ROOT_W-2:0], take_w};
        end
        if (sq_done_w) small_q <= root_q < MAG_LO;
        if (fin_w) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
          if (!small_q) begin
            sin_o <= lane_val[0];
            cos_o <= lane_val[1];
          end
        end
      end
    end
  end

  // one restoring divider lane per axis
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [DR_W-1:0]     rem_q, rem_t;
    logic [DIV_ITER-1:0] quo_q;
    logic                neg_q, ge_w;
    logic signed [OUT_W-1:0] mag_s;

    assign ge_w  = rem_q >= {2'b00, root_q};
    assign rem_t = ge_w ? (rem_q - {2'b00, root_q}) : rem_q;
    assign mag_s = $signed({1'b0, quo_q});
    assign lane_val[g] = neg_q ? -mag_s : mag_s;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_q <= '0;
        quo_q <= '0;
        neg_q <= 1'b0;
      end else begin
        if (start_w) neg_q <= x_w[g][ST_W-1];
        if (sq_done_w) begin
          rem_q <= {2'b00, abs_q[g]};
          quo_q <= '0;
        end else if (div_step_w) begin
          rem_q <= {rem_t[DR_W-2:0], 1'b0};
          quo_q <= {quo_q[DIV_ITER-2:0], ge_w};
        end
      end
    end
  end

  // checks on the iterative datapath
  logic [RAD_W+1:0] r_lo, r_hi;
  assign r_lo = (RAD_W+2)'(root_q) * (RAD_W+2)'(root_q);
  assign r_hi = ((RAD_W+2)'(root_q) + (RAD_W+2)'(1)) * ((RAD_W+2)'(root_q) + (RAD_W+2)'(1));

  p_sqrt_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sq_done_w |-> ((r_lo <= (RAD_W+2)'(rad_keep_q)) && (r_hi > (RAD_W+2)'(rad_keep_q))));

  p_unit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (($signed(sin_o) <= 16'sd16384) && ($signed(sin_o) >= -16'sd16384) &&
                 ($signed(cos_o) <= 16'sd16384) && ($signed(cos_o) >= -16'sd16384)));

  p_out_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_w |=> ($stable(sin_o) && $stable(cos_o)));

  p_hold_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_w && small_q) |=> ($stable(sin_o) && $stable(cos_o) && valid_o));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_start_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/gsync_top.sv
module gsync_top
  import gsync_pkg::*;
#(
  parameter int KT        = KT_COEF,
  parameter int WT        = WT_COEF,
  parameter int MAG_LIMIT = MAG_MIN
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid_i,
  input  logic signed [15:0] va_i,
  input  logic signed [15:0] vb_i,
  input  logic signed [15:0] vc_i,
  output logic              sync_valid_o,
  output logic signed [15:0] sin_o,
  output logic signed [15:0] cos_o
);
  logic signed [AB_W-1:0] alpha_w, beta_w;
  logic signed [ST_W-1:0] xa_w, xb_w;
  logic frame_v_w, state_v_w;

  gsync_clarke u_clarke (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (smp_valid_i),
    .va_i       (va_i),
    .vb_i       (vb_i),
    .vc_i       (vc_i),
    .alpha_o    (alpha_w),
    .beta_o     (beta_w),
    .v_o        (frame_v_w)
  );

  gsync_stf #(.KT(KT), .WT(WT)) u_stf (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (frame_v_w),
    .alpha_i (alpha_w),
    .beta_i  (beta_w),
    .xa_o    (xa_w),
    .xb_o    (xb_w),
    .v_o     (state_v_w)
  );

  gsync_norm #(.MAG_LIMIT(MAG_LIMIT)) u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (state_v_w),
    .xa_i    (xa_w),
    .xb_i    (xb_w),
    .valid_o (sync_valid_o),
    .sin_o   (sin_o),
    .cos_o   (cos_o)
  );

  // the filter state is only updated between strobe and result (R3)
  p_update_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_v_w |-> $past(smp_valid_i, 2));
endmodule

// File: tb/gsync_top_tb_top.sv
module gsync_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid_i = 1'b0;
  logic signed [15:0] va_i = '0, vb_i = '0, vc_i = '0;
  logic sync_valid_o;
  logic signed [15:0] sin_o, cos_o;

  int n_chk = 0;
  int n_bad = 0;
  longint mxa = 0, mxb = 0, msin = 0, mcos = 0;
  int last_lat = 0;

  always #2 clk = ~clk;

  gsync_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i),
    .va_i(va_i), .vb_i(vb_i), .vc_i(vc_i),
    .sync_valid_o(sync_valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference arithmetic written from the requirements
  function automatic longint fdiv(input longint n, input longint d);
    longint q;
    q = n / d;
    if ((n % d) != 0 && n < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint clamp(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint isqrt(input longint v);
    longint lo, hi, mid;
    lo = 0; hi = 262144;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid;
    end
    return lo;
  endfunction

  task automatic model_step(input longint va, input longint vb, input longint vc);
    longint al, be, na, nb, m;
    al = fdiv((2 * va - vb - vc) * 10923, 32768);
    be = fdiv((vb - vc) * 18919, 32768);
    na = clamp(mxa + fdiv(131 * (al - mxa), 65536) - fdiv(2059 * mxb, 65536));
    nb = clamp(mxb + fdiv(131 * (be - mxb), 65536) + fdiv(2059 * mxa, 65536));
    mxa = na; mxb = nb;
    m = isqrt(na * na + nb * nb);
    if (m >= 64) begin
      msin = (na * 16384) / m;
      mcos = (nb * 16384) / m;
    end
  endtask

  // send one sample, wait for the result, verify timing (R7) and values
  task automatic apply(input int va, input int vb, input int vc, input string req);
    int cyc;
    bit seen;
    @(negedge clk);
    smp_valid_i = 1'b1; va_i = 16'(va); vb_i = 16'(vb); vc_i = 16'(vc);
    @(posedge clk);
    @(negedge clk);
    smp_valid_i = 1'b0;
    cyc = 0; seen = 0;
    while (!seen && cyc < 80) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (sync_valid_o) seen = 1;
    end
    last_lat = cyc;
    model_step(va, vb, vc);
    check(seen && cyc == 37, "R7 latency", cyc, 37);
    check(sin_o == 16'(msin) && cos_o == 16'(mcos), {req, " sin"}, sin_o, msin);
    if (cos_o != 16'(mcos)) $display("  (cos actual=%0d expected=%0d)", cos_o, mcos);
    @(negedge clk);
    check(!sync_valid_o, "R7 pulse width", sync_valid_o, 0);
  endtask

  function automatic int vgen(input real a1, input real h3, input real h5, input real h7,
                              input real h9, input real th);
    real v;
    v = a1 * $sin(th) + h3 * $sin(3.0 * th) + h5 * $sin(5.0 * th) + h7 * $sin(7.0 * th) + h9 * $sin(9.0 * th);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(!sync_valid_o, "R1 valid low in reset", sync_valid_o, 0);
    check(sin_o == 0 && cos_o == 0, "R1 outputs zero in reset", sin_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sin_o == 0 && cos_o == 0, "R1 outputs zero after release", cos_o, 0);
  endtask

  task automatic t_hold_small();
    apply(0, 0, 0, "R6 zero sample");
    check(sin_o == 0 && cos_o == 0, "R6 held at zero", sin_o, 0);
    apply(300, -150, -150, "R6 small sample");
    check(sin_o == 0 && cos_o == 0, "R6 small magnitude held", cos_o, 0);
  endtask

  task automatic t_clean();
    real pi2 = 6.283185307179586;
    for (int n = 0; n < 400; n++) begin
      real th;
      th = pi2 * n / 200.0;
      apply(vgen(20000.0, 0, 0, 0, 0, th), vgen(20000.0, 0, 0, 0, 0, th - pi2 / 3.0),
            vgen(20000.0, 0, 0, 0, 0, th + pi2 / 3.0), "R2/R3/R4/R5 balanced");
    end
  endtask

  task automatic t_distorted();
    real pi2 = 6.283185307179586;
    for (int n = 0; n < 3000; n++) begin
      real th, thn, es, ec;
      th = pi2 * n / 200.0;
      thn = pi2 * (n + 1) / 200.0;
      apply(vgen(20000.0, 2450.0, 1840.0, 1230.0, 610.0, th),
            vgen(15100.0, 1840.0, 1230.0, 610.0, 610.0, th - pi2 / 3.0),
            vgen(17550.0, 610.0, 610.0, 610.0, 610.0, th + pi2 / 3.0), "R2/R3/R4/R5 distorted");
      if (n >= 2800) begin
        es = $sin(thn) * 16384.0;
        ec = -$cos(thn) * 16384.0;
        check(($itor(sin_o) - es) < 819.0 && ($itor(sin_o) - es) > -819.0, "R8 sin phase", sin_o, $rtoi(es));
        check(($itor(cos_o) - ec) < 819.0 && ($itor(cos_o) - ec) > -819.0, "R8 cos phase", cos_o, $rtoi(ec));
      end
    end
  endtask

  task automatic t_reset_mid();
    check(sin_o != 0 || cos_o != 0, "R1 outputs nonzero before reset", sin_o, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sin_o == 0 && cos_o == 0 && !sync_valid_o, "R1 mid-run reset clears outputs", sin_o, 0);
    rst_n = 1'b1;
    mxa = 0; mxb = 0; msin = 0; mcos = 0;
    apply(0, 0, 0, "R1 states cleared");
    check(sin_o == 0 && cos_o == 0, "R1 filter states zero after reset", cos_o, 0);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    t_reset();
    t_hold_small();
    t_clean();
    t_distorted();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule